// File: doc/BRIEF.md
# 6502 Bus Cycle Supervisor

This block runs an 8-bit 6502-style processor bus one CPU clock cycle at a time. It divides the system clock down to make the CPU clock, and it can slow that clock or hold it. In the low half of each CPU cycle it turns on the address buffers onto a shared 16-bit port and samples the address, R/W and SYNC. It then classifies the address against a memory map given on configuration inputs. The map has three kinds of region: plain RAM, a write-protected ROM window in the same RAM, and a window of virtual hardware that the block serves itself.

In the high half the sampled cycle is served. A RAM read asserts RAM output enable and a RAM write asserts write enable. A ROM read asserts output enable, and a ROM write asserts neither strobe. A virtual read drives the low byte of the port from the peripheral side. A virtual write captures the byte and hands it to the peripheral side with a one-tick strobe. The RAM strobes, the bank bit and the five CPU control lines (NMI, IRQ, RDY, RES, SO) all reach the outside through an 8-bit control latch. That latch is loaded only by a strobe, and the strobe never overlaps the address-buffer enable.

Top module: `bus_cycle_supervisor`

## Requirements
- R1: After reset `cpu_clk` is high. While `run` is 1, each half of the CPU clock lasts exactly `HALF_TICKS` system clock cycles.
- R2: With `run` at 0 the CPU clock stops only in its high half and stays high. A low half that has started always completes after `HALF_TICKS` cycles. Setting `run` to 1 resumes the clock.
- R3: `addr_en` is asserted only while `cpu_clk` is low and `ctl_le` is low. Address, R/W (1 = read, 0 = write) and SYNC are sampled from the port while `addr_en` is active.
- R4: The control latch loads its 8 inputs only while `ctl_le` is 1 and otherwise holds them. Bit 0 drives RAM OE, bit 1 RAM WE, bit 2 A16, bit 3 NMI, bit 4 IRQ, bit 5 RDY, bit 6 RES and bit 7 SO. The control lines are active high, and reset leaves RES asserted with every other bit clear. A request input changed in the high half appears on its output at the next falling CPU clock edge.
- R5: For an address in no special range, a read asserts `ram_oe` and a write asserts `ram_we` during the high half. The two are never asserted together.
- R6: For an address inside [`rom_lo`, `rom_hi`], a read asserts `ram_oe` and a write asserts neither strobe, so the stored bytes stay unchanged.
- R7: For an address inside [`virt_lo`, `virt_hi`], both RAM strobes stay off. A read drives `data_out` = `virt_rdata` with `data_oe`. A write pulses `virt_wr` for one tick after the high half, with `virt_wdata` taken from port bits 7:0 and `virt_addr` holding the address.
- R8: If the address falls in both windows, the virtual window takes priority over the ROM window.
- R9: `ram_a16` follows `bank_sel`, so each bank holds its own contents.
- R10: `data_oe` is asserted only in the high half of a virtual read cycle, never together with `ram_oe` or `ram_we`.
- R11: `cyc_fetch` gives the SYNC value sampled in the current cycle throughout the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 lets the CPU clock run, 0 holds it high |
| bus_in | input | 16 | Shared port: address in low half, data on bits 7:0 in high half |
| cpu_rw | input | 1 | CPU R/W, 1 = read |
| cpu_sync | input | 1 | CPU opcode-fetch indicator |
| rom_lo | input | 16 | First address of ROM window |
| rom_hi | input | 16 | Last address of ROM window |
| virt_lo | input | 16 | First address of virtual window |
| virt_hi | input | 16 | Last address of virtual window |
| bank_sel | input | 1 | RAM bank for CPU accesses |
| req_nmi | input | 1 | Requested NMI level |
| req_irq | input | 1 | Requested IRQ level |
| req_rdy | input | 1 | Requested RDY level |
| req_res | input | 1 | Requested RES level |
| req_so | input | 1 | Requested SO level |
| virt_rdata | input | 8 | Read data from the virtual peripheral side |
| cpu_clk | output | 1 | Generated CPU clock |
| addr_en | output | 1 | Address-buffer enable |
| ctl_le | output | 1 | Control latch strobe |
| ram_oe | output | 1 | RAM output enable (latched) |
| ram_we | output | 1 | RAM write enable (latched) |
| ram_a16 | output | 1 | RAM bank bit (latched) |
| cpu_nmi | output | 1 | NMI line (latched) |
| cpu_irq | output | 1 | IRQ line (latched) |
| cpu_rdy | output | 1 | RDY line (latched) |
| cpu_res | output | 1 | RES line (latched) |
| cpu_so | output | 1 | SO line (latched) |
| data_out | output | 8 | Data driven onto port bits 7:0 |
| data_oe | output | 1 | Enable for `data_out` |
| virt_addr | output | 16 | Address of the current cycle |
| virt_wr | output | 1 | One-tick virtual write strobe |
| virt_wdata | output | 8 | Captured virtual write data |
| cyc_fetch | output | 1 | Sampled SYNC of the current cycle |

## Verification
The assertions check the bus-safety rules on every cycle. These are: the buffer enable stays inside the low half and never meets the latch strobe, the RAM strobes exclude each other, `data_oe` never meets a RAM strobe or the low half, and the latch holds its outputs between strobes. Only the bench scenarios can show that each region gets the right strobes and data and that the ROM bytes survive writes. The same holds for virtual-over-ROM priority, bank separation, the exact half-cycle lengths and the rule that a stop happens only in the high half.

// File: rtl/sup_pkg.sv
// Shared definitions for the bus cycle supervisor: region kinds and the
// bit positions of the external control latch (order fixed by the board).
package sup_pkg;
    typedef enum logic [1:0] {
        RGN_RAM  = 2'd0,
        RGN_ROM  = 2'd1,
        RGN_VIRT = 2'd2
    } region_e;

    localparam int LATCH_W = 8;
    localparam int LB_OE   = 0;
    localparam int LB_WE   = 1;
    localparam int LB_A16  = 2;
    localparam int LB_NMI  = 3;
    localparam int LB_IRQ  = 4;
    localparam int LB_RDY  = 5;
    localparam int LB_RES  = 6;
    localparam int LB_SO   = 7;

    // Reset value: CPU held in reset, RAM strobes and other lines off.
    localparam logic [LATCH_W-1:0] LATCH_RST = 8'b0100_0000;
endpackage

// File: rtl/sup_phase_gen.sv
// CPU clock phase generator.
// Divides the system clock into a high half and a low half of HALF_TICKS
// ticks each and exposes the tick count within the current half.
// Assumes HALF_TICKS >= 4. A stop request holds the count one tick before
// the end of the high half, so the clock can only stop while high.
module sup_phase_gen #(
    parameter int HALF_TICKS = 62,
    localparam int CW = $clog2(HALF_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic          phase_hi,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);
    localparam logic [CW-1:0] HOLD = CW'(HALF_TICKS - 2);

    // Advance the count, swap halves at the end, hold in the high half on stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_hi <= 1'b1;
            cnt      <= '0;
        end else if (cnt == LAST) begin
            phase_hi <= ~phase_hi;
            cnt      <= '0;
        end else if (phase_hi && cnt == HOLD && !run) begin
            cnt      <= cnt;
        end else begin
            cnt      <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sup_region_decode.sv
// Address region classifier.
// Purely combinational: compares an address against two inclusive windows.
// The virtual window wins over the ROM window; everything else is RAM.
module sup_region_decode
    import sup_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] rom_lo,
    input  logic [AW-1:0] rom_hi,
    input  logic [AW-1:0] virt_lo,
    input  logic [AW-1:0] virt_hi,
    output region_e       region
);
    logic in_rom;
    logic in_virt;

    // Window membership tests.
    always_comb begin
        in_rom  = (addr >= rom_lo)  && (addr <= rom_hi);
        in_virt = (addr >= virt_lo) && (addr <= virt_hi);
    end

    // Priority selection of the region kind.
    always_comb begin
        if (in_virt)      region = RGN_VIRT;
        else if (in_rom)  region = RGN_ROM;
        else              region = RGN_RAM;
    end
endmodule

// File: rtl/sup_ctl_latch.sv
// Strobed control latch, modelled as a clocked register per bit.
// Each bit loads its input while the strobe is high and holds otherwise.
// Assumes the strobe is driven from registered logic in the same domain.
module sup_ctl_latch #(
    parameter int                W       = 8,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        // Load bit b on strobe, otherwise keep its value.
        always_ff @(posedge clk) begin
            if (!rst_n)  q[b] <= RST_VAL[b];
            else if (le) q[b] <= d[b];
        end
    end
endmodule

// File: rtl/bus_cycle_supervisor.sv
// Per-cycle supervisor for a 6502-style CPU bus.
// Generates the CPU clock, samples address/R/W/SYNC in the low half through
// the address buffers, classifies the address, and serves the high half from
// RAM, write-protected RAM (ROM) or the virtual peripheral side. All RAM and
// CPU control lines pass through a strobed latch loaded at the end of each
// half, never while the address buffers are enabled.
// Assumes HALF_TICKS >= 4 and R/W high for reads.
module bus_cycle_supervisor
    import sup_pkg::*;
#(
    parameter int HALF_TICKS = 62,
    parameter int AW         = 16,
    parameter int DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [AW-1:0] bus_in,
    input  logic          cpu_rw,
    input  logic          cpu_sync,
    input  logic [AW-1:0] rom_lo,
    input  logic [AW-1:0] rom_hi,
    input  logic [AW-1:0] virt_lo,
    input  logic [AW-1:0] virt_hi,
    input  logic          bank_sel,
    input  logic          req_nmi,
    input  logic          req_irq,
    input  logic          req_rdy,
    input  logic          req_res,
    input  logic          req_so,
    input  logic [DW-1:0] virt_rdata,
    output logic          cpu_clk,
    output logic          addr_en,
    output logic          ctl_le,
    output logic          ram_oe,
    output logic          ram_we,
    output logic          ram_a16,
    output logic          cpu_nmi,
    output logic          cpu_irq,
    output logic          cpu_rdy,
    output logic          cpu_res,
    output logic          cpu_so,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic [AW-1:0] virt_addr,
    output logic          virt_wr,
    output logic [DW-1:0] virt_wdata,
    output logic          cyc_fetch
);
    localparam int CW  = $clog2(HALF_TICKS);
    localparam int SMP = HALF_TICKS / 2 - 1;
    localparam logic [CW-1:0] C_LAST = CW'(HALF_TICKS - 1);
    localparam logic [CW-1:0] C_SMP  = CW'(SMP);
    localparam logic [CW-1:0] C_DEC  = CW'(SMP + 1);

    logic                phase_hi;
    logic [CW-1:0]       cnt;
    logic                low_end;
    logic                high_end;
    logic [AW-1:0]       addr_q;
    logic                rw_q;
    logic                sync_q;
    region_e             rgn_now;
    region_e             rgn_q;
    logic [LATCH_W-1:0]  latch_d;
    logic [LATCH_W-1:0]  latch_q;

    sup_phase_gen #(.HALF_TICKS(HALF_TICKS)) i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .phase_hi (phase_hi),
        .cnt      (cnt)
    );

    // Half-cycle boundary markers and bus-buffer / strobe timing.
    always_comb begin
        low_end  = !phase_hi && (cnt == C_LAST);
        high_end =  phase_hi && (cnt == C_LAST);
        addr_en  = !phase_hi && (cnt != '0) && (cnt <= C_SMP);
        ctl_le   = low_end || high_end;
    end

    // Capture address, direction and fetch flag on the last enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rw_q   <= 1'b1;
            sync_q <= 1'b0;
        end else if (!phase_hi && cnt == C_SMP) begin
            addr_q <= bus_in;
            rw_q   <= cpu_rw;
            sync_q <= cpu_sync;
        end
    end

    sup_region_decode #(.AW(AW)) i_decode (
        .addr    (addr_q),
        .rom_lo  (rom_lo),
        .rom_hi  (rom_hi),
        .virt_lo (virt_lo),
        .virt_hi (virt_hi),
        .region  (rgn_now)
    );

    // Register the region one tick after sampling, still inside the low half.
    always_ff @(posedge clk) begin
        if (!rst_n)                             rgn_q <= RGN_RAM;
        else if (!phase_hi && cnt == C_DEC)     rgn_q <= rgn_now;
    end

    // Next latch contents: strobes for the coming high half, off at its end.
    always_comb begin
        latch_d          = '0;
        latch_d[LB_OE]   = low_end && (rgn_q != RGN_VIRT) && rw_q;
        latch_d[LB_WE]   = low_end && (rgn_q == RGN_RAM) && !rw_q;
        latch_d[LB_A16]  = bank_sel;
        latch_d[LB_NMI]  = req_nmi;
        latch_d[LB_IRQ]  = req_irq;
        latch_d[LB_RDY]  = req_rdy;
        latch_d[LB_RES]  = req_res;
        latch_d[LB_SO]   = req_so;
    end

    sup_ctl_latch #(.W(LATCH_W), .RST_VAL(LATCH_RST)) i_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (ctl_le),
        .d     (latch_d),
        .q     (latch_q)
    );

    // Fan the latch bits out to the named lines.
    always_comb begin
        ram_oe  = latch_q[LB_OE];
        ram_we  = latch_q[LB_WE];
        ram_a16 = latch_q[LB_A16];
        cpu_nmi = latch_q[LB_NMI];
        cpu_irq = latch_q[LB_IRQ];
        cpu_rdy = latch_q[LB_RDY];
        cpu_res = latch_q[LB_RES];
        cpu_so  = latch_q[LB_SO];
    end

    // Virtual read path: drive the data byte only in a virtual read's high half.
    always_comb begin
        cpu_clk   = phase_hi;
        data_oe   = phase_hi && (rgn_q == RGN_VIRT) && rw_q;
        data_out  = virt_rdata;
        virt_addr = addr_q;
        cyc_fetch = sync_q;
    end

    // Virtual write path: capture the byte at the end of the high half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            virt_wr    <= 1'b0;
            virt_wdata <= '0;
        end else begin
            virt_wr <= high_end && (rgn_q == RGN_VIRT) && !rw_q;
            if (high_end) virt_wdata <= bus_in[DW-1:0];
        end
    end
endmodule

// File: rtl/sup_checker.sv
// Bus-safety checker for bus_cycle_supervisor, attached with bind.
// Assumes synchronous active-low reset on clk.
module sup_checker (
    input logic clk,
    input logic rst_n,
    input logic cpu_clk,
    input logic addr_en,
    input logic ctl_le,
    input logic ram_oe,
    input logic ram_we,
    input logic ram_a16,
    input logic cpu_nmi,
    input logic cpu_irq,
    input logic cpu_rdy,
    input logic cpu_res,
    input logic cpu_so,
    input logic data_oe
);
    // R3: buffers only in the low half
    p_en_low_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en |-> !cpu_clk);

    // R3: buffers never with the latch strobe
    p_en_vs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en |-> !ctl_le);

    // R4: latch outputs hold when the strobe was inactive
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_le) |-> $stable({ram_oe, ram_we, ram_a16, cpu_nmi,
                                     cpu_irq, cpu_rdy, cpu_res, cpu_so}));

    // R5: read and write strobes exclusive
    p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_oe && ram_we));

    // R10: block drives the port only in the high half, never against the RAM
    p_no_contention_r10: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (cpu_clk && !ram_oe && !ram_we));
endmodule

bind bus_cycle_supervisor sup_checker i_sup_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_clk (cpu_clk),
    .addr_en (addr_en),
    .ctl_le  (ctl_le),
    .ram_oe  (ram_oe),
    .ram_we  (ram_we),
    .ram_a16 (ram_a16),
    .cpu_nmi (cpu_nmi),
    .cpu_irq (cpu_irq),
    .cpu_rdy (cpu_rdy),
    .cpu_res (cpu_res),
    .cpu_so  (cpu_so),
    .data_oe (data_oe)
);

// File: tb/test_bus_cycle_supervisor.sv
module test_bus_cycle_supervisor;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b1;
    logic [15:0] bus_in = '0;
    logic        cpu_rw = 1'b1;
    logic        cpu_sync = 1'b0;
    logic [15:0] rom_lo = 16'hF000, rom_hi = 16'hFFFF;
    logic [15:0] virt_lo = 16'hE800, virt_hi = 16'hE80F;
    logic        bank_sel = 1'b0;
    logic        req_nmi = 0, req_irq = 0, req_rdy = 0, req_res = 1, req_so = 0;
    logic [7:0]  virt_rdata;
    logic        cpu_clk, addr_en, ctl_le, ram_oe, ram_we, ram_a16;
    logic        cpu_nmi, cpu_irq, cpu_rdy, cpu_res, cpu_so;
    logic [7:0]  data_out, virt_wdata;
    logic        data_oe, virt_wr, cyc_fetch;
    logic [15:0] virt_addr;

    int n_chk = 0, n_fail = 0, n_bad = 0;
    logic [15:0] cur_addr = '0;
    logic        cur_rw = 1'b1;
    logic [7:0]  ram_mem [512];
    logic [7:0]  vreg [16];

    always #4 clk = ~clk;

    bus_cycle_supervisor #(.HALF_TICKS(HALF)) i_bus_cycle_supervisor (.*);

    function automatic logic [8:0] ridx(input logic [15:0] a, input logic b);
        return {b, a[15:12], a[3:0]};
    endfunction

    assign virt_rdata = vreg[virt_addr[3:0]];

    // RAM array model and virtual peripheral registers
    always @(posedge clk) begin
        if (rst_n && ram_we) ram_mem[ridx(cur_addr, ram_a16)] <= bus_in[7:0];
        if (rst_n && virt_wr) vreg[virt_addr[3:0]] <= virt_wdata;
    end

    // Bus-safety monitor (R3, R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if ((ram_oe && data_oe) || (data_oe && (!cpu_clk || !cur_rw)) ||
                (addr_en && (cpu_clk || ctl_le)))
                n_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cycle(input logic [15:0] a, input logic rw, input logic sy,
                            input logic [7:0] wd, output logic oe, output logic we,
                            output logic doe, output logic [7:0] rd, output logic ft);
        @(negedge cpu_clk); #1;
        bus_in = a; cpu_rw = rw; cpu_sync = sy; cur_addr = a; cur_rw = rw;
        @(posedge cpu_clk); #1;
        bus_in[7:0] = rw ? 8'h00 : wd;
        repeat (3) @(posedge clk); #1;
        oe = ram_oe; we = ram_we; doe = data_oe; ft = cyc_fetch;
        rd = ram_oe ? ram_mem[ridx(a, ram_a16)] : (data_oe ? data_out : 8'hEE);
    endtask

    // {addr, rw(1=read), sync, wdata, exp_oe, exp_we, exp_doe, exp_rdata}
    localparam logic [36:0] VEC [13] = '{
        {16'h0010, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b0, 8'h00},
        {16'h0010, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h5A},
        {16'hF010, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 8'h00},
        {16'hF010, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'hC3},
        {16'hE803, 1'b0, 1'b0, 8'h77, 1'b0, 1'b0, 1'b0, 8'h00},
        {16'hE803, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h77},
        {16'hE805, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00},
        {16'hE7FF, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0, 8'h00},
        {16'hE810, 1'b0, 1'b0, 8'h4D, 1'b0, 1'b1, 1'b0, 8'h00},
        {16'hE7FF, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h3C},
        {16'hE810, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h4D},
        {16'hFFFF, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
        {16'hFFFF, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'hE1}
    };

    task automatic finish_run();
        if (n_bad != 0) $display("FAIL R10 actual=%0d expected=0 (bus-safety violations)", n_bad);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + 1, n_fail + (n_bad != 0 ? 1 : 0));
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        n_fail++;
        finish_run();
    end

    initial begin
        logic oe, we, doe, ft;
        logic [7:0] rd;
        int n;
        for (int i = 0; i < 512; i++) ram_mem[i] = 8'h00;
        for (int i = 0; i < 16; i++) vreg[i] = 8'h00;
        ram_mem[ridx(16'hF010, 1'b0)] = 8'hC3;
        ram_mem[ridx(16'hFFFF, 1'b0)] = 8'hE1;

        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        #1;
        // R1/R4 reset state
        chk(cpu_clk == 1'b1, "R1 reset clock high", cpu_clk, 1);
        chk({cpu_so, cpu_res, cpu_rdy, cpu_irq, cpu_nmi, ram_a16, ram_we, ram_oe} == 8'h40,
            "R4 reset latch", {cpu_so, cpu_res, cpu_rdy, cpu_irq, cpu_nmi, ram_a16, ram_we, ram_oe}, 8'h40);
        chk(!data_oe && !addr_en, "R10 reset no drive", {data_oe, addr_en}, 0);

        // R4 control lines follow requests after a full cycle
        req_res = 0; req_rdy = 1; req_nmi = 1; req_so = 1;
        @(posedge cpu_clk); @(posedge cpu_clk); #1;
        chk({cpu_so, cpu_res, cpu_rdy, cpu_nmi} == 4'b1011, "R4 line bits",
            {cpu_so, cpu_res, cpu_rdy, cpu_nmi}, 4'b1011);
        req_nmi = 0; req_so = 0;
        // R4 hold between strobes, load on next falling edge
        @(posedge cpu_clk); #1; req_irq = 1;
        repeat (3) @(posedge clk); #1;
        chk(cpu_irq == 1'b0, "R4 latch holds", cpu_irq, 0);
        @(negedge cpu_clk); #1;
        chk(cpu_irq == 1'b1, "R4 latch loads", cpu_irq, 1);
        req_irq = 0;

        // Vector table: R5 RAM, R6 ROM, R7 virtual, R11 fetch flag
        for (int i = 0; i < 13; i++) begin
            logic [36:0] v;
            v = VEC[i];
            do_cycle(v[36:21], v[20], v[19], v[18:11], oe, we, doe, rd, ft);
            chk({oe, we, doe} == v[10:8], $sformatf("R5/R6/R7 strobes row %0d", i),
                {oe, we, doe}, v[10:8]);
            chk(ft == v[19], $sformatf("R11 fetch row %0d", i), ft, v[19]);
            if (v[20]) chk(rd == v[7:0], $sformatf("R5/R6/R7 read data row %0d", i), rd, v[7:0]);
        end

        // R9 bank separation
        bank_sel = 1'b1;
        do_cycle(16'h0010, 1'b0, 1'b0, 8'h99, oe, we, doe, rd, ft);
        chk(we && ram_a16, "R9 bank1 write", {we, ram_a16}, 2'b11);
        do_cycle(16'h0010, 1'b1, 1'b0, 8'h00, oe, we, doe, rd, ft);
        chk(rd == 8'h99, "R9 bank1 read", rd, 8'h99);
        bank_sel = 1'b0;
        do_cycle(16'h0010, 1'b1, 1'b0, 8'h00, oe, we, doe, rd, ft);
        chk(rd == 8'h5A && !ram_a16, "R9 bank0 kept", rd, 8'h5A);

        // R8 virtual window wins over ROM
        virt_lo = 16'hF010; virt_hi = 16'hF010;
        do_cycle(16'hF010, 1'b1, 1'b0, 8'h00, oe, we, doe, rd, ft);
        chk(doe && !oe, "R8 priority strobes", {doe, oe}, 2'b10);
        chk(rd == 8'h00, "R8 priority data", rd, 8'h00);
        virt_lo = 16'hE800; virt_hi = 16'hE80F;

        // R1 half lengths
        @(posedge cpu_clk); #1;
        n = 0;
        while (cpu_clk) begin @(posedge clk); #1; n++; end
        chk(n == HALF, "R1 high half length", n, HALF);
        n = 0;
        while (!cpu_clk) begin @(posedge clk); #1; n++; end
        chk(n == HALF, "R1 low half length", n, HALF);

        // R2 stop requested in low half: low completes, then holds high
        @(negedge cpu_clk); #1;
        run = 1'b0;
        n = 0;
        while (!cpu_clk && n < 100) begin @(posedge clk); #1; n++; end
        chk(n == HALF, "R2 low half completes", n, HALF);
        repeat (50) @(posedge clk); #1;
        chk(cpu_clk == 1'b1, "R2 held high", cpu_clk, 1);
        run = 1'b1;
        n = 0;
        while (cpu_clk && n < 100) begin @(posedge clk); #1; n++; end
        chk(cpu_clk == 1'b0, "R2 resumes", cpu_clk, 0);

        // R6 ROM contents untouched by writes
        chk(ram_mem[ridx(16'hF010, 1'b0)] == 8'hC3, "R6 ROM byte F010",
            ram_mem[ridx(16'hF010, 1'b0)], 8'hC3);
        chk(ram_mem[ridx(16'hFFFF, 1'b0)] == 8'hE1, "R6 ROM byte FFFF",
            ram_mem[ridx(16'hFFFF, 1'b0)], 8'hE1);

        finish_run();
    end
endmodule